// File: doc/BRIEF.md
# Line Fill Buffer Snoop Responder

This block answers an external snoop that lands on a cache line while the line is still being brought in through the line fill buffer. The fill buffer tells the block which line it is filling. When a snoop strobe arrives with an address on that line, the block takes the snoop in one of two ways, chosen by a mode input sampled on that edge. It either signals a hit to the system or keeps the hit output low. It then waits for the bus to be given back to it.

The interrupted fill cycle restarts once the back-off input and the address-hold input are both low. On that edge the block works out the state the filled line will take in the cache. It presents that state together with a one-cycle restart strobe. For a snoop taken as a hit, the state follows the invalidate request captured with the snoop. For a snoop taken as a miss, it follows the cache-enable, write-back select and page write-through inputs seen on the restart edge.

Top module: `lfb_snoop_responder`

## Requirements
- R1: During and right after a synchronous reset, `snoop_hit` and `restart_pulse` are 0 and `line_state` is 2'b00 (invalid).
- R2: A snoop strobe whose line address matches the pending fill, while `fill_progress_hit` is 1, raises `snoop_hit` on the following cycle. The output stays high until the restart edge, where it drops as `restart_pulse` rises.
- R3: A matching snoop taken while `fill_progress_hit` is 0 keeps `snoop_hit` at 0, and it still leads to a restart.
- R4: `restart_pulse` is high for exactly one cycle, in the cycle after the first edge following a matching snoop where `backoff` and `addr_hold` are both 0. It never fires while either is high. `line_state` changes only on that edge.
- R5: After a snoop taken as a hit, the restart presents 2'b01 (shared) if `snoop_inv` was 0 on the snoop edge, and 2'b00 (invalid) if it was 1.
- R6: After a snoop taken as a miss, the restart presents a state that depends on `cache_en`, `wb_sel` and `page_wt` on the restart edge. It is 2'b00 if `cache_en` is 0. It is 2'b10 (exclusive) if `cache_en`=1, `wb_sel`=1 and `page_wt`=0. It is 2'b01 (shared) if `cache_en`=1 and either `wb_sel`=0 or `page_wt`=1. The value 2'b11 (modified) is never produced.
- R7: Changes to `snoop_inv` or `fill_progress_hit` after the snoop edge do not alter the result. Changes to the cacheability inputs before the restart edge do not alter it either.
- R8: Only address bits at and above `LINE_OFS_W` are compared. A snoop to another line leaves `snoop_hit` at 0, causes no restart, and keeps the fill pending. A snoop that differs only in offset bits matches.
- R9: A snoop strobe is ignored when no fill is pending. It is also ignored while an earlier matching snoop is waiting for restart.
- R10: `fill_start` marks `fill_addr` as the pending line. `fill_end` without a matching snoop clears it with no restart. A matching snoop on the same edge as `fill_end` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_start | input | 1 | Opens a fill for the line at `fill_addr` |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_end | input | 1 | Fill finished with no snoop interaction |
| snoop_strobe | input | 1 | External snoop address strobe |
| snoop_addr | input | ADDR_W | Snoop address |
| snoop_inv | input | 1 | Snoop asks for invalidation |
| fill_progress_hit | input | 1 | 1: take a matching snoop as a hit; 0: as a miss |
| cache_en | input | 1 | Line is cacheable |
| wb_sel | input | 1 | 1: write-back, 0: write-through |
| page_wt | input | 1 | Page write-through override |
| backoff | input | 1 | Bus back-off request |
| addr_hold | input | 1 | Address-hold request |
| snoop_hit | output | 1 | Snoop hit indication to the system |
| restart_pulse | output | 1 | One-cycle strobe at fill restart; qualifies `line_state` |
| line_state | output | 2 | Final line state: 00 invalid, 01 shared, 10 exclusive, 11 modified |

## Verification
The checker watches every cycle for the rules that follow from the ports alone. The restart strobe lasts one cycle and comes only after a cycle with both bus holds low. The line state moves only with the strobe, and it never reads modified. The hit output rises only after a snoop strobe and is low when the strobe fires. A hit-taken restart never reports exclusive. What the state should be in each case is left to the bench scenarios. These cover the invalidate request against the cacheability combinations, capture against late input changes, line versus offset matching, and snoops that must be ignored.

// File: rtl/lfb_snoop_pkg.sv
package lfb_snoop_pkg;

  typedef enum logic [1:0] {
    LS_INVALID   = 2'b00,
    LS_SHARED    = 2'b01,
    LS_EXCLUSIVE = 2'b10,
    LS_MODIFIED  = 2'b11
  } line_state_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_FILL = 2'b01,
    PH_HOLD = 2'b10
  } phase_t;

  typedef struct packed {
    logic treat_hit;
    logic inv;
  } snoop_ctx_t;

  typedef struct packed {
    logic en;
    logic wb;
    logic pwt;
  } cache_attr_t;

endpackage

// File: rtl/lfb_line_match.sv
module lfb_line_match #(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              match
);
  localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W)'((64'd1 << LINE_OFS_W) - 64'd1));

  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else if (load) line_q <= load_addr;
  end

  assign diff  = (line_q ^ probe_addr) & TAG_MASK;
  assign match = (diff == '0);
endmodule

// File: rtl/lfb_snoop_capture.sv
module lfb_snoop_capture
  import lfb_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_en,
  input  logic       mode_hit,
  input  logic       inv_req,
  output snoop_ctx_t ctx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctx <= '0;
    end else if (cap_en) begin
      ctx.treat_hit <= mode_hit;
      ctx.inv       <= inv_req;
    end
  end
endmodule

// File: rtl/lfb_state_resolve.sv
module lfb_state_resolve
  import lfb_snoop_pkg::*;
(
  input  snoop_ctx_t  ctx,
  input  cache_attr_t attr,
  output line_state_t next_state
);
  always_comb begin
    if (ctx.treat_hit) begin
      next_state = ctx.inv ? LS_INVALID : LS_SHARED;
    end else if (!attr.en) begin
      next_state = LS_INVALID;
    end else if (attr.wb && !attr.pwt) begin
      next_state = LS_EXCLUSIVE;
    end else begin
      next_state = LS_SHARED;
    end
  end
endmodule

// File: rtl/lfb_snoop_responder.sv
module lfb_snoop_responder
  import lfb_snoop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_start,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_end,
  input  logic              snoop_strobe,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              snoop_inv,
  input  logic              fill_progress_hit,
  input  logic              cache_en,
  input  logic              wb_sel,
  input  logic              page_wt,
  input  logic              backoff,
  input  logic              addr_hold,
  output logic              snoop_hit,
  output logic              restart_pulse,
  output logic [1:0]        line_state
);
  phase_t      phase_q;
  logic        line_hit;
  logic        take_snoop;
  logic        bus_free;
  snoop_ctx_t  ctx;
  cache_attr_t attr;
  line_state_t resolved;
  logic        hit_q;
  logic        pulse_q;
  line_state_t state_q;

  assign take_snoop = (phase_q == PH_FILL) && snoop_strobe && line_hit;
  assign bus_free   = !backoff && !addr_hold;
  assign attr       = '{en: cache_en, wb: wb_sel, pwt: page_wt};

  lfb_line_match #(
    .ADDR_W    (ADDR_W),
    .LINE_OFS_W(LINE_OFS_W)
  ) match_i (
    .clk       (clk),
    .rst       (rst),
    .load      ((phase_q == PH_IDLE) && fill_start),
    .load_addr (fill_addr),
    .probe_addr(snoop_addr),
    .match     (line_hit)
  );

  lfb_snoop_capture capture_i (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (take_snoop),
    .mode_hit(fill_progress_hit),
    .inv_req (snoop_inv),
    .ctx     (ctx)
  );

  lfb_state_resolve resolve_i (
    .ctx       (ctx),
    .attr      (attr),
    .next_state(resolved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      hit_q   <= 1'b0;
      pulse_q <= 1'b0;
      state_q <= LS_INVALID;
    end else begin
      pulse_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (fill_start) phase_q <= PH_FILL;
        PH_FILL: begin
          if (take_snoop) begin
            phase_q <= PH_HOLD;
            hit_q   <= fill_progress_hit;
          end else if (fill_end) begin
            phase_q <= PH_IDLE;
          end
        end
        PH_HOLD: begin
          if (bus_free) begin
            phase_q <= PH_IDLE;
            hit_q   <= 1'b0;
            pulse_q <= 1'b1;
            state_q <= resolved;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign snoop_hit     = hit_q;
  assign restart_pulse = pulse_q;
  assign line_state    = state_q;
endmodule

// File: rtl/lfb_snoop_responder_chk.sv
module lfb_snoop_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       snoop_strobe,
  input logic       backoff,
  input logic       addr_hold,
  input logic       snoop_hit,
  input logic       restart_pulse,
  input logic [1:0] line_state
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> !restart_pulse);

  assert_restart_bus_free_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(restart_pulse) |-> ($past(backoff) == 1'b0 && $past(addr_hold) == 1'b0));

  assert_state_only_on_restart_R4: assert property (@(posedge clk) disable iff (rst)
    !restart_pulse |-> $stable(line_state));

  assert_never_modified_R6: assert property (@(posedge clk) disable iff (rst)
    line_state != 2'b11);

  assert_hit_low_at_restart_R2: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> !snoop_hit);

  assert_hit_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(snoop_hit) |-> $past(snoop_strobe));

  assert_hit_path_no_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (restart_pulse && $past(snoop_hit)) |-> line_state != 2'b10);
endmodule

bind lfb_snoop_responder lfb_snoop_responder_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .snoop_strobe (snoop_strobe),
  .backoff      (backoff),
  .addr_hold    (addr_hold),
  .snoop_hit    (snoop_hit),
  .restart_pulse(restart_pulse),
  .line_state   (line_state)
);

// File: tb/lfb_snoop_responder_tb_top.sv
module lfb_snoop_responder_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_start = 0, fill_end = 0;
  logic [AW-1:0] fill_addr = '0, snoop_addr = '0;
  logic          snoop_strobe = 0, snoop_inv = 0, fill_progress_hit = 0;
  logic          cache_en = 0, wb_sel = 0, page_wt = 0;
  logic          backoff = 1, addr_hold = 1;
  logic          snoop_hit, restart_pulse;
  logic [1:0]    line_state;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  lfb_snoop_responder #(.ADDR_W(AW), .LINE_OFS_W(5)) dut_i (
    .clk(clk), .rst(rst),
    .fill_start(fill_start), .fill_addr(fill_addr), .fill_end(fill_end),
    .snoop_strobe(snoop_strobe), .snoop_addr(snoop_addr), .snoop_inv(snoop_inv),
    .fill_progress_hit(fill_progress_hit),
    .cache_en(cache_en), .wb_sel(wb_sel), .page_wt(page_wt),
    .backoff(backoff), .addr_hold(addr_hold),
    .snoop_hit(snoop_hit), .restart_pulse(restart_pulse), .line_state(line_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every restart pops one expected state (R4, R5, R6)
  always @(negedge clk) begin
    if (!rst && restart_pulse) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: actual unexpected restart expected none");
      end else begin
        check(tag_q.pop_front(), {30'd0, line_state}, {30'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_fill(input logic [AW-1:0] a);
    @(negedge clk); fill_start = 1; fill_addr = a;
    @(negedge clk); fill_start = 0;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic inv, input logic mode,
                       input logic exp_hit, input string req);
    @(negedge clk); snoop_strobe = 1; snoop_addr = a; snoop_inv = inv; fill_progress_hit = mode;
    @(negedge clk); snoop_strobe = 0;
    check(req, {31'd0, snoop_hit}, {31'd0, exp_hit});
  endtask

  task automatic release_bus(input logic en, input logic wb, input logic pwt,
                             input logic [1:0] exp_state, input string req);
    @(negedge clk);
    cache_en = en; wb_sel = wb; page_wt = pwt; backoff = 0; addr_hold = 0;
    exp_q.push_back(exp_state); tag_q.push_back(req);
    @(negedge clk);
    backoff = 1; addr_hold = 1;
    check("R2 hit low at restart", {31'd0, snoop_hit}, 32'd0);
    check("R4 pulse seen", {31'd0, restart_pulse}, 32'd1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, restart_pulse}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 hit at reset", {31'd0, snoop_hit}, 0);
    check("R1 pulse at reset", {31'd0, restart_pulse}, 0);
    check("R1 state at reset", {30'd0, line_state}, 0);
    rst = 0;
    idle(1);
    check("R1 state after reset", {30'd0, line_state}, 0);

    // R2/R5/R7: hit, inv low, late changes ignored, partial release
    open_fill(32'h0000_1000);
    snoop(32'h0000_1004, 0, 1, 1, "R2 hit raised");
    snoop_inv = 1; fill_progress_hit = 0;
    backoff = 0; idle(3);
    check("R4 no restart with addr_hold", {31'd0, restart_pulse}, 0);
    check("R2 hit held", {31'd0, snoop_hit}, 1);
    release_bus(0, 0, 0, 2'b01, "R5 R7 shared after hit");
    check("R4 state held", {30'd0, line_state}, 2'b01);

    // R5 invalidate request
    open_fill(32'h0000_2000);
    snoop(32'h0000_2000, 1, 1, 1, "R2 hit inv");
    release_bus(1, 1, 0, 2'b00, "R5 invalid after hit with inv");

    // R3/R6/R7: miss paths, cacheability changes before restart ignored
    open_fill(32'h0000_3000);
    snoop(32'h0000_301F, 0, 0, 0, "R3 miss no hit");
    cache_en = 0; idle(2);
    check("R3 hit stays low", {31'd0, snoop_hit}, 0);
    release_bus(1, 1, 0, 2'b10, "R6 R7 exclusive");
    open_fill(32'h0000_4000);
    snoop(32'h0000_4000, 1, 0, 0, "R3 miss");
    release_bus(1, 0, 0, 2'b01, "R6 write-through shared");
    open_fill(32'h0000_5000);
    snoop(32'h0000_5000, 0, 0, 0, "R3 miss");
    release_bus(1, 1, 1, 2'b01, "R6 page write-through shared");
    open_fill(32'h0000_6000);
    snoop(32'h0000_6000, 0, 0, 0, "R3 miss");
    release_bus(0, 1, 0, 2'b00, "R6 uncacheable invalid");

    // R8: other line ignored, fill stays pending, no restart on release
    open_fill(32'h0000_7000);
    snoop(32'h0000_7020, 0, 1, 0, "R8 other line no hit");
    backoff = 0; addr_hold = 0; idle(3);
    check("R8 no restart", {31'd0, restart_pulse}, 0);
    backoff = 1; addr_hold = 1;
    snoop(32'h0000_7011, 0, 1, 1, "R8 offset-only match hits");
    // R9: second snoop while waiting ignored
    snoop(32'h0000_7000, 1, 0, 1, "R9 second snoop ignored");
    release_bus(1, 1, 0, 2'b01, "R9 first snoop decides");

    // R9: no pending fill
    snoop(32'h0000_7000, 0, 1, 0, "R9 no fill no hit");
    // R10: fill_end clears pending
    open_fill(32'h0000_8000);
    @(negedge clk); fill_end = 1;
    @(negedge clk); fill_end = 0;
    snoop(32'h0000_8000, 0, 1, 0, "R10 fill ended no hit");
    backoff = 0; addr_hold = 0; idle(3);
    check("R10 no restart", {31'd0, restart_pulse}, 0);
    backoff = 1; addr_hold = 1;
    // R10: snoop wins over fill_end on same edge
    open_fill(32'h0000_9000);
    @(negedge clk); fill_end = 1; snoop_strobe = 1; snoop_addr = 32'h0000_9000;
    snoop_inv = 0; fill_progress_hit = 1;
    @(negedge clk); fill_end = 0; snoop_strobe = 0;
    check("R10 snoop priority", {31'd0, snoop_hit}, 1);
    release_bus(0, 0, 0, 2'b01, "R10 restart after priority");

    idle(2);
    check("R4 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule